// File: doc/BRIEF.md
# In-Flight Prefetch Tracking Monitor

This block sits next to the tag array of a direct-mapped cache and follows every software prefetch from the cycle it is issued until its fill response comes back. Each cache frame has a small state machine: idle, in transit (a prefetch owns the frame and its data is still on the way), or killed (the owning prefetch was cancelled, but its response has not yet come back and must be discarded). Three event streams drive it: prefetch commands, demand loads/stores, and fill responses. From their interaction it sorts outstanding prefetches into cancelled or late ones.

Three saturating counters are exposed for software to read: prefetches issued, prefetches cancelled and prefetches late. A runtime agent can read them each cycle and derive the cancelled and late fractions, which it uses to tune its prefetch distance. A single clear strobe zeroes all three counters together. What happens after a prefetch's data has arrived (use, replacement, invalidation) is not observed.

The demand port is a valid/ready stream. `dm_ready` is low while `dm_valid` targets a line whose prefetch is still in transit. The requester must then hold `dm_valid` and `dm_addr` steady until `dm_ready` is high. The prefetch and fill ports are never back-pressured: each cycle with `pf_valid` or `fill_valid` high is one event.

Top module: `prefetch_transit_monitor`

## Requirements
- R1: After reset all three counters read zero, every frame is idle, and `dm_ready` is high.
- R2: Every cycle with `pf_valid` high adds one to the issued count. This includes duplicates and dropped prefetches.
- R3: A prefetch to an idle frame records its tag and places the frame in transit.
- R4: A prefetch with a different tag to a frame that is in transit is dropped and adds one to the cancel count. The resident prefetch stays in transit.
- R5: A demand access with a different tag to an in-transit frame cancels the resident prefetch. It adds one to the cancel count, is not blocked, and leaves the frame killed.
- R6: A demand access with the same tag as an in-transit prefetch is blocked (`dm_ready` low) until the fill arrives. It adds exactly one to the late count per demand, however long it waits.
- R7: A fill whose tag matches an in-transit frame returns that frame to idle. A fill with any other tag, or one that finds the frame idle, has no effect.
- R8: A killed frame drops any new prefetch, counting it as cancelled, until the fill carrying the killed tag arrives. That fill is discarded and the frame becomes idle.
- R9: A prefetch with the same tag as the prefetch already in transit in that frame is a duplicate. It is neither cancelled nor re-recorded.
- R10: Within one cycle, events on one frame take effect in this order: fill, then demand, then prefetch. A demand that meets its own fill in the same cycle is therefore neither blocked nor counted late. A demand that kills a frame makes a same-cycle prefetch to that frame a drop, so the cancel count rises by two.
- R11: Each counter is CNT_W bits wide (default 32) and holds at all ones instead of wrapping. `cnt_clr` zeroes all three counters on the next edge and overrides any increment in that cycle.
- R12: With the default geometry, the frame index is address bits [11:4] (256 frames of 16 bytes) and the tag is bits [31:12]. Addresses that differ only in bits [3:0] are the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch command this cycle |
| pf_addr | input | ADDR_W | Prefetch byte address |
| dm_valid | input | 1 | Demand load/store presented |
| dm_addr | input | ADDR_W | Demand byte address |
| dm_ready | output | 1 | Demand accepted; low while its line is in transit |
| fill_valid | input | 1 | Fill response this cycle |
| fill_addr | input | ADDR_W | Fill response line address |
| cnt_clr | input | 1 | Clear strobe for all counters |
| cnt_issued | output | CNT_W | Prefetches issued |
| cnt_cancel | output | CNT_W | Prefetches cancelled |
| cnt_late | output | CNT_W | Late prefetches |

## Verification
The collision that matters most is a fill response and a demand access landing on the same frame in the same cycle. The fill must win, so the demand passes without being counted late. The bench provokes this by holding a blocked demand and delivering the matching fill in the cycle it is still presented, then judges `dm_ready` before the edge and the unchanged late count after it. A second collision puts a killing demand and a prefetch on one frame together, where the cancel count must rise by two.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [1:0] {
    FR_IDLE    = 2'd0,
    FR_TRANSIT = 2'd1,
    FR_KILLED  = 2'd2
  } frame_st_e;
endpackage

// File: rtl/pft_frame_slot.sv
module pft_frame_slot
  import pft_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_sel,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dm_sel,
  input  logic [TAG_W-1:0] dm_tag,
  input  logic             pf_sel,
  input  logic [TAG_W-1:0] pf_tag,
  output logic             dm_block,
  output logic             dm_kill,
  output logic             pf_drop
);
  frame_st_e        st_q, st_fill, st_dm, st_d;
  logic [TAG_W-1:0] tag_q, tag_d;

  // Fill is applied first, then the demand, then the prefetch.
  always_comb begin
    st_fill = st_q;
    if (fill_sel && (st_q != FR_IDLE) && (fill_tag == tag_q)) st_fill = FR_IDLE;

    st_dm    = st_fill;
    dm_block = 1'b0;
    dm_kill  = 1'b0;
    if (dm_sel && (st_fill == FR_TRANSIT)) begin
      if (dm_tag == tag_q) begin
        dm_block = 1'b1;
      end else begin
        dm_kill = 1'b1;
        st_dm   = FR_KILLED;
      end
    end

    st_d    = st_dm;
    tag_d   = tag_q;
    pf_drop = 1'b0;
    if (pf_sel) begin
      if (st_dm == FR_IDLE) begin
        st_d  = FR_TRANSIT;
        tag_d = pf_tag;
      end else if (!((st_dm == FR_TRANSIT) && (pf_tag == tag_q))) begin
        pf_drop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      tag_q <= '0;
    end else begin
      st_q  <= st_d;
      tag_q <= tag_d;
    end
  end
endmodule

// File: rtl/pft_sat_counter.sv
module pft_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     value
);
  logic [W:0] sum;

  always_comb sum = {1'b0, value} + (W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) value <= '0;
    else if (sum[W])   value <= '1;
    else               value <= sum[W-1:0];
  end
endmodule

// File: rtl/prefetch_transit_monitor.sv
module prefetch_transit_monitor #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int CACHE_BYTES = 4096,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              dm_valid,
  input  logic [ADDR_W-1:0] dm_addr,
  output logic              dm_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_issued,
  output logic [CNT_W-1:0]  cnt_cancel,
  output logic [CNT_W-1:0]  cnt_late
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int FRAMES = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W  = $clog2(FRAMES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0] pf_idx, dm_idx, fill_idx;
  logic [TAG_W-1:0] pf_tag, dm_tag, fill_tag;
  logic             unused_offset_bits;

  assign pf_idx   = pf_addr[OFF_W +: IDX_W];
  assign dm_idx   = dm_addr[OFF_W +: IDX_W];
  assign fill_idx = fill_addr[OFF_W +: IDX_W];
  assign pf_tag   = pf_addr[ADDR_W-1 -: TAG_W];
  assign dm_tag   = dm_addr[ADDR_W-1 -: TAG_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset_bits = ^{pf_addr[OFF_W-1:0], dm_addr[OFF_W-1:0], fill_addr[OFF_W-1:0]};

  logic [FRAMES-1:0] blk_vec, kill_vec, drop_vec;

  for (genvar g = 0; g < FRAMES; g++) begin : g_frame
    pft_frame_slot #(.TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_sel (fill_valid && (fill_idx == IDX_W'(g))),
      .fill_tag (fill_tag),
      .dm_sel   (dm_valid && (dm_idx == IDX_W'(g))),
      .dm_tag   (dm_tag),
      .pf_sel   (pf_valid && (pf_idx == IDX_W'(g))),
      .pf_tag   (pf_tag),
      .dm_block (blk_vec[g]),
      .dm_kill  (kill_vec[g]),
      .pf_drop  (drop_vec[g])
    );
  end

  logic dm_block, dm_wait_q, late_hit;
  logic [1:0] cancel_inc;

  assign dm_block   = |blk_vec;
  assign dm_ready   = !dm_block;
  assign late_hit   = dm_block && !dm_wait_q;
  assign cancel_inc = {1'b0, |kill_vec} + {1'b0, |drop_vec};

  // Remembers that the presented demand was already counted late.
  always_ff @(posedge clk) begin
    if (!rst_n) dm_wait_q <= 1'b0;
    else        dm_wait_q <= dm_valid && dm_block;
  end

  pft_sat_counter #(.W(CNT_W), .INC_W(1)) u_cnt_issued (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(pf_valid), .value(cnt_issued)
  );
  pft_sat_counter #(.W(CNT_W), .INC_W(2)) u_cnt_cancel (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cancel_inc), .value(cnt_cancel)
  );
  pft_sat_counter #(.W(CNT_W), .INC_W(1)) u_cnt_late (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(late_hit), .value(cnt_late)
  );
endmodule

// File: rtl/pft_checker.sv
module pft_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pf_valid,
  input logic             dm_valid,
  input logic             dm_ready,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_issued,
  input logic [CNT_W-1:0] cnt_cancel,
  input logic [CNT_W-1:0] cnt_late
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  // R2
  issued_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !cnt_clr && cnt_issued != MAXV) |=> cnt_issued == $past(cnt_issued) + CNT_W'(1));

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_issued == '0 && cnt_cancel == '0 && cnt_late == '0));

  // R6
  late_needs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clr && !(dm_valid && !dm_ready)) |=> cnt_late == $past(cnt_late));

  // R10
  cancel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_cancel >= $past(cnt_cancel)) && (cnt_cancel - $past(cnt_cancel) <= CNT_W'(2)));

  // R2
  issued_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_valid && !cnt_clr) |=> $stable(cnt_issued));
endmodule

bind prefetch_transit_monitor pft_checker #(.CNT_W(CNT_W)) u_pft_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pf_valid   (pf_valid),
  .dm_valid   (dm_valid),
  .dm_ready   (dm_ready),
  .cnt_clr    (cnt_clr),
  .cnt_issued (cnt_issued),
  .cnt_cancel (cnt_cancel),
  .cnt_late   (cnt_late)
);

// File: tb/test_prefetch_transit_monitor.sv
module test_prefetch_transit_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_valid = 1'b0, dm_valid = 1'b0, fill_valid = 1'b0, cnt_clr = 1'b0;
  logic [31:0] pf_addr = '0, dm_addr = '0, fill_addr = '0;
  logic        dm_ready, dm_ready_n3;
  logic [31:0] cnt_issued, cnt_cancel, cnt_late;
  logic [2:0]  n_issued, n_cancel, n_late;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prefetch_transit_monitor i_prefetch_transit_monitor (
    .clk(clk), .rst_n(rst_n),
    .pf_valid(pf_valid), .pf_addr(pf_addr),
    .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_ready(dm_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .cnt_clr(cnt_clr),
    .cnt_issued(cnt_issued), .cnt_cancel(cnt_cancel), .cnt_late(cnt_late)
  );

  // Narrow-counter copy on the same stimulus, used for saturation (R11).
  prefetch_transit_monitor #(.CNT_W(3)) i_prefetch_transit_monitor_narrow (
    .clk(clk), .rst_n(rst_n),
    .pf_valid(pf_valid), .pf_addr(pf_addr),
    .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_ready(dm_ready_n3),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .cnt_clr(cnt_clr),
    .cnt_issued(n_issued), .cnt_cancel(n_cancel), .cnt_late(n_late)
  );

  // Line address: tag in [31:12], frame index in [11:4] (R12).
  function automatic logic [31:0] mk(int t, int i);
    return (32'(t) << 12) | (32'(i) << 4);
  endfunction

  localparam logic [31:0] A = mk(1, 5);
  localparam logic [31:0] B = mk(2, 5) | 32'h0000_0008;
  localparam logic [31:0] C = mk(3, 9);
  localparam logic [31:0] D = mk(4, 9);
  localparam logic [31:0] E = mk(1, 6);

  typedef struct packed {
    logic        pv;
    logic [31:0] pa;
    logic        dv;
    logic [31:0] da;
    logic        fv;
    logic [31:0] fa;
    logic        rdy;
    logic [7:0]  iss;
    logic [7:0]  can;
    logic [7:0]  lat;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, A, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd1,  8'd0, 8'd0, 8'd3},  // R3 claim frame 5
    '{1'b0, 32'h0, 1'b1, A, 1'b0, 32'h0, 1'b0, 8'd1,  8'd0, 8'd1, 8'd6},  // R6 late demand
    '{1'b0, 32'h0, 1'b1, A, 1'b0, 32'h0, 1'b0, 8'd1,  8'd0, 8'd1, 8'd6},  // R6 held, counted once
    '{1'b0, 32'h0, 1'b1, A, 1'b1, A,     1'b1, 8'd1,  8'd0, 8'd1, 8'd10}, // R10 fill before demand
    '{1'b1, A, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd2,  8'd0, 8'd1, 8'd3},  // R3 reclaim
    '{1'b1, A, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd3,  8'd0, 8'd1, 8'd9},  // R9 duplicate
    '{1'b1, B, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd4,  8'd1, 8'd1, 8'd4},  // R4 newcomer dropped
    '{1'b0, 32'h0, 1'b1, A, 1'b0, 32'h0, 1'b0, 8'd4,  8'd1, 8'd2, 8'd4},  // R4 resident survives
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, B, 1'b1, 8'd4,  8'd1, 8'd2, 8'd7},  // R7 foreign fill
    '{1'b0, 32'h0, 1'b1, A, 1'b0, 32'h0, 1'b0, 8'd4,  8'd1, 8'd3, 8'd7},  // R7 still in transit
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, A, 1'b1, 8'd4,  8'd1, 8'd3, 8'd7},  // R7 matching fill
    '{1'b0, 32'h0, 1'b1, A, 1'b0, 32'h0, 1'b1, 8'd4,  8'd1, 8'd3, 8'd7},  // R7 frame idle again
    '{1'b1, C, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd5,  8'd1, 8'd3, 8'd3},  // R3 claim frame 9
    '{1'b0, 32'h0, 1'b1, D, 1'b0, 32'h0, 1'b1, 8'd5,  8'd2, 8'd3, 8'd5},  // R5 demand kills
    '{1'b0, 32'h0, 1'b1, C, 1'b0, 32'h0, 1'b1, 8'd5,  8'd2, 8'd3, 8'd5},  // R5 no longer transit
    '{1'b1, D, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd6,  8'd3, 8'd3, 8'd8},  // R8 killed frame drops
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, C, 1'b1, 8'd6,  8'd3, 8'd3, 8'd8},  // R8 orphan fill
    '{1'b1, D, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd7,  8'd3, 8'd3, 8'd8},  // R8 frame free again
    '{1'b0, 32'h0, 1'b1, D, 1'b0, 32'h0, 1'b0, 8'd7,  8'd3, 8'd4, 8'd8},  // R8 new owner in transit
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, D, 1'b1, 8'd7,  8'd3, 8'd4, 8'd7},  // R7
    '{1'b1, E, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd8,  8'd3, 8'd4, 8'd12}, // R12 tag 1 frame 6
    '{1'b0, 32'h0, 1'b1, A, 1'b0, 32'h0, 1'b1, 8'd8,  8'd3, 8'd4, 8'd12}, // R12 same tag frame 5
    '{1'b0, 32'h0, 1'b1, E | 32'h3, 1'b0, 32'h0, 1'b0, 8'd8, 8'd3, 8'd5, 8'd12}, // R12 offset ignored
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, E, 1'b1, 8'd8,  8'd3, 8'd5, 8'd7},  // R7
    '{1'b1, C, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 8'd9,  8'd3, 8'd5, 8'd2},  // R2
    '{1'b1, D, 1'b1, D, 1'b0, 32'h0,     1'b1, 8'd10, 8'd5, 8'd5, 8'd10}, // R10 kill then drop
    '{1'b0, 32'h0, 1'b0, 32'h0, 1'b1, C, 1'b1, 8'd10, 8'd5, 8'd5, 8'd8}   // R8 orphan fill
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle: inputs set after a rising edge, dm_ready sampled
  // before the next edge, counters sampled just after it.
  task automatic step(input logic pv, input logic [31:0] pa,
                      input logic dv, input logic [31:0] da,
                      input logic fv, input logic [31:0] fa,
                      input logic clr, output logic rdy);
    pf_valid = pv; pf_addr = pa;
    dm_valid = dv; dm_addr = da;
    fill_valid = fv; fill_addr = fa;
    cnt_clr = clr;
    #1 rdy = dm_ready;
    @(posedge clk);
    #1;
    pf_valid = 1'b0; dm_valid = 1'b0; fill_valid = 1'b0; cnt_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic rdy;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1 reset state
    check(cnt_issued == 0 && cnt_cancel == 0 && cnt_late == 0, "R1", "counters after reset",
          cnt_issued + cnt_cancel + cnt_late, 0);
    check(dm_ready == 1'b1, "R1", "dm_ready after reset", dm_ready, 1);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].pv, VEC[k].pa, VEC[k].dv, VEC[k].da, VEC[k].fv, VEC[k].fa, 1'b0, rdy);
      check(rdy == VEC[k].rdy, $sformatf("R%0d", VEC[k].req), $sformatf("vector %0d dm_ready", k),
            rdy, VEC[k].rdy);
      check(cnt_issued == 32'(VEC[k].iss), $sformatf("R%0d", VEC[k].req),
            $sformatf("vector %0d issued", k), cnt_issued, VEC[k].iss);
      check(cnt_cancel == 32'(VEC[k].can), $sformatf("R%0d", VEC[k].req),
            $sformatf("vector %0d cancelled", k), cnt_cancel, VEC[k].can);
      check(cnt_late == 32'(VEC[k].lat), $sformatf("R%0d", VEC[k].req),
            $sformatf("vector %0d late", k), cnt_late, VEC[k].lat);
    end

    // R11 saturation on the 3-bit copy: 10 issued clamps at 7
    check(n_issued == 3'd7, "R11", "narrow issued saturates", n_issued, 7);
    check(n_cancel == 3'd5, "R11", "narrow cancel below limit", n_cancel, 5);

    // R11 clear strobe zeroes all three
    step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, rdy);
    check(cnt_issued == 0 && cnt_cancel == 0 && cnt_late == 0, "R11", "clear zeroes",
          cnt_issued + cnt_cancel + cnt_late, 0);
    check(n_issued == 0, "R11", "narrow clear", n_issued, 0);

    // R11 clear wins over a same-cycle prefetch (frame 9 idle, so it is claimed)
    step(1'b1, C, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, rdy);
    check(cnt_issued == 0, "R11", "clear overrides increment", cnt_issued, 0);

    // R9 / R2 the claim above stuck: same line again is a duplicate
    step(1'b1, C, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, rdy);
    check(cnt_issued == 1, "R2", "issued after clear", cnt_issued, 1);
    check(cnt_cancel == 0, "R9", "duplicate not cancelled", cnt_cancel, 0);

    // R6 demand to that line now blocks and counts late once
    step(1'b0, 32'h0, 1'b1, C, 1'b0, 32'h0, 1'b0, rdy);
    check(rdy == 1'b0, "R6", "blocked after duplicate", rdy, 0);
    check(cnt_late == 1, "R6", "late after clear", cnt_late, 1);

    finish_run();
  end
endmodule